// File: doc/BRIEF.md
# Combined Ready/Data Serial Port with Clock-Level Sleep Control

This block is the device-side digital front of a sampling converter. A conversion source hands it a fresh result word. The block then pulls its single serial output low to announce that the word is waiting. A host reads the word by toggling the serial clock, and each rising edge moves the next bit onto that same output, most significant bit first. The serial clock comes from the host, so the block synchronises it to the master clock before it detects any edges.

The serial clock level also controls power. If the host holds the clock high long enough after a word has been announced, the block goes to sleep and forces the output high. A low level wakes it. After a programmable wake delay, the block announces the word on the result port without waiting for a strobe. If the host gave one clock pulse beyond the word length during the last readout, the block notes a calibration request. The next wakeup then waits the longer calibration delay before it announces data.

Top module: `sdo_sleep_port`

## Requirements
- R1: When `res_valid` is high and no readout is part-way through (state idle, or a word fully shifted), the block loads `res_data` and drives `dout` low within 3 master clock cycles.
- R2: Successive synchronised rising edges of `sclk` present the loaded word on `dout` MSB first, one bit per edge, for WIDTH edges.
- R3: A rising edge of `sclk` after all WIDTH bits have been shifted drives `dout` high and sets `cal_pending` to 1.
- R4: Once a ready indication has been given, `sclk` held high for T_ACT consecutive synchronised cycles puts the block to sleep (`asleep` = 1). A shorter high period does not.
- R5: While `asleep` is 1, `dout` is 1.
- R6: A low `sclk` level during sleep clears `asleep` within 3 master clock cycles.
- R7: After a wakeup with `cal_pending` = 0, `dout` stays high for T_WAKE cycles and then goes low with `res_data` loaded as the new word.
- R8: After a wakeup with `cal_pending` = 1, `dout` stays high for T_CAL cycles, then goes low, and `cal_pending` returns to 0.
- R9: Entering sleep part-way through a readout discards the unsent bits. After wakeup the shifted bits belong to the newly loaded word.
- R10: A `res_valid` pulse during a partial readout is ignored, and the word being read continues unchanged.
- R11: After reset, `dout` = 1, `asleep` = 0 and `cal_pending` = 0.
- R12: With no ready indication since reset or since the last wakeup, holding `sclk` high never causes sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Host serial clock, asynchronous to clk |
| res_valid | input | 1 | Strobe marking a new result on res_data |
| res_data | input | WIDTH | Result word from the conversion source |
| dout | output | 1 | Combined ready flag (low) and serial data |
| asleep | output | 1 | High while the block is in sleep |
| cal_pending | output | 1 | High while a calibration wakeup is armed |

## Verification
The bench builds the block with WIDTH = 24, T_ACT = 40, T_WAKE = 30 and T_CAL = 90. These short delays let it observe the sleep threshold from both sides, and let it see the output stay high through each wake delay and then fall, within a few hundred cycles. The large gap between T_WAKE and T_CAL separates a plain wakeup from a calibration wakeup. The full 24-bit word length means the extra-pulse rule is tested on the real readout length.

// File: rtl/sdo_port_pkg.sv
package sdo_port_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RDY   = 2'd1,
        ST_SLEEP = 2'd2,
        ST_WAKE  = 2'd3
    } port_st_e;
endpackage

// File: rtl/sclk_sync.sv
module sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~prev_q;

    p_rise_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/level_timer.sv
module level_timer #(
    parameter int LIMIT = 160000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic level,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en || !level)                 cnt_d = '0;
        else if (cnt_q != CW'(LIMIT))      cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = en && level && (cnt_q == CW'(LIMIT));

    p_expire_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !level) |=> !expired);
endmodule

// File: rtl/sdo_sleep_port.sv
module sdo_sleep_port
    import sdo_port_pkg::*;
#(
    parameter int WIDTH  = 24,
    parameter int T_ACT  = 160000,
    parameter int T_WAKE = 170000,
    parameter int T_CAL  = 516000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             res_valid,
    input  logic [WIDTH-1:0] res_data,
    output logic             dout,
    output logic             asleep,
    output logic             cal_pending
);
    localparam int BCW  = $clog2(WIDTH + 1);
    localparam int WMAX = (T_CAL > T_WAKE) ? T_CAL : T_WAKE;
    localparam int WCW  = $clog2(WMAX + 1);

    typedef struct packed {
        port_st_e         st;
        logic [WIDTH-1:0] sh;
        logic [BCW-1:0]   bcnt;
        logic [WCW-1:0]   wcnt;
        logic             dout;
        logic             seen;
        logic             cal;
    } port_regs_t;

    port_regs_t r_d, r_q;

    logic sclk_lvl, sclk_rise, hi_exp, awake_io;

    sclk_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sclk),
        .level    (sclk_lvl),
        .rise     (sclk_rise)
    );

    assign awake_io = (r_q.st == ST_IDLE) || (r_q.st == ST_RDY);

    level_timer #(.LIMIT(T_ACT)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (r_q.seen && awake_io),
        .level   (sclk_lvl),
        .expired (hi_exp)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.dout = 1'b1;
                if (res_valid) begin
                    r_d.sh   = res_data;
                    r_d.bcnt = '0;
                    r_d.dout = 1'b0;
                    r_d.seen = 1'b1;
                    r_d.st   = ST_RDY;
                end
            end
            ST_RDY: begin
                if (sclk_rise) begin
                    if (r_q.bcnt != BCW'(WIDTH)) begin
                        r_d.dout = r_q.sh[WIDTH-1];
                        r_d.sh   = {r_q.sh[WIDTH-2:0], 1'b0};
                        r_d.bcnt = r_q.bcnt + 1'b1;
                    end else begin
                        r_d.cal  = 1'b1;
                        r_d.dout = 1'b1;
                        r_d.st   = ST_IDLE;
                    end
                end else if (res_valid &&
                             (r_q.bcnt == '0 || r_q.bcnt == BCW'(WIDTH))) begin
                    r_d.sh   = res_data;
                    r_d.bcnt = '0;
                    r_d.dout = 1'b0;
                end
            end
            ST_SLEEP: begin
                r_d.dout = 1'b1;
                if (!sclk_lvl) begin
                    r_d.st   = ST_WAKE;
                    r_d.wcnt = r_q.cal ? WCW'(T_CAL - 1) : WCW'(T_WAKE - 1);
                end
            end
            ST_WAKE: begin
                r_d.dout = 1'b1;
                if (r_q.wcnt == '0) begin
                    r_d.sh   = res_data;
                    r_d.bcnt = '0;
                    r_d.dout = 1'b0;
                    r_d.cal  = 1'b0;
                    r_d.seen = 1'b1;
                    r_d.st   = ST_RDY;
                end else begin
                    r_d.wcnt = r_q.wcnt - 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (hi_exp && awake_io) begin
            r_d.st   = ST_SLEEP;
            r_d.dout = 1'b1;
            r_d.seen = 1'b0;
            r_d.bcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.dout <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout        = r_q.dout;
    assign asleep      = (r_q.st == ST_SLEEP);
    assign cal_pending = r_q.cal;

    p_sleep_dout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> dout);

    p_wake_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !sclk_lvl) |=> !asleep);

    p_sleep_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_exp && awake_io) |=> asleep);

    p_cal_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RDY && sclk_rise && r_q.bcnt == BCW'(WIDTH) && !hi_exp)
        |=> (cal_pending && dout));

    p_wake_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAKE && r_q.wcnt == '0) |=> (!dout && !cal_pending));
endmodule

// File: tb/sdo_sleep_port_bench.sv
module sdo_sleep_port_bench;
    localparam int W    = 24;
    localparam int TACT = 40;
    localparam int TWK  = 30;
    localparam int TCAL = 90;
    localparam logic [W-1:0] VEC [4] = '{24'hA5C3F0, 24'h000001, 24'h800000, 24'h5A3C96};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic res_valid = 1'b0;
    logic [W-1:0] res_data = '0;
    logic dout, asleep, cal_pending;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdo_sleep_port #(.WIDTH(W), .T_ACT(TACT), .T_WAKE(TWK), .T_CAL(TCAL)) u_sdo_sleep_port (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .res_valid(res_valid),
        .res_data(res_data), .dout(dout), .asleep(asleep), .cal_pending(cal_pending)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [W-1:0] w);
        @(negedge clk);
        res_data  = w;
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        wait_n(3);
    endtask

    task automatic pulse(output logic b);
        @(negedge clk);
        sclk = 1'b1;
        wait_n(6);
        b = dout;
        sclk = 1'b0;
        wait_n(6);
    endtask

    task automatic read_bits(input int n, inout logic [W-1:0] acc);
        logic b;
        for (int i = 0; i < n; i++) begin
            pulse(b);
            acc = {acc[W-2:0], b};
        end
    endtask

    initial begin
        logic [W-1:0] acc;
        logic b;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        chk(dout == 1'b1, "R11 dout", 32'(dout), 1);
        chk(asleep == 1'b0, "R11 asleep", 32'(asleep), 0);
        chk(cal_pending == 1'b0, "R11 cal", 32'(cal_pending), 0);

        // R12: long high with no ready indication
        sclk = 1'b1;
        wait_n(TACT + 20);
        chk(asleep == 1'b0, "R12 no sleep", 32'(asleep), 0);
        chk(dout == 1'b1, "R12 dout", 32'(dout), 1);
        sclk = 1'b0;
        wait_n(5);

        // Vector table: R1 ready low, R2 MSB-first word
        for (int v = 0; v < 4; v++) begin
            load(VEC[v]);
            chk(dout == 1'b0, "R1 ready low", 32'(dout), 0);
            acc = '0;
            read_bits(W, acc);
            chk(acc == VEC[v], "R2 word", 32'(acc), 32'(VEC[v]));
        end

        // R10: strobe during partial readout ignored
        load(24'h3C5A69);
        acc = '0;
        read_bits(3, acc);
        @(negedge clk);
        res_data = 24'hFFFFFF;
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        read_bits(W - 3, acc);
        chk(acc == 24'h3C5A69, "R10 word kept", 32'(acc), 32'h3C5A69);

        // R4/R5/R6/R7/R9: sleep mid-readout, plain wake
        load(24'hC0FFEE);
        acc = '0;
        read_bits(5, acc);
        @(negedge clk);
        sclk = 1'b1;
        wait_n(TACT - 10);
        chk(asleep == 1'b0, "R4 not yet", 32'(asleep), 0);
        wait_n(20);
        chk(asleep == 1'b1, "R4 asleep", 32'(asleep), 1);
        chk(dout == 1'b1, "R5 dout high", 32'(dout), 1);
        res_data = 24'h123456;
        sclk = 1'b0;
        wait_n(4);
        chk(asleep == 1'b0, "R6 woke", 32'(asleep), 0);
        wait_n(20);
        chk(dout == 1'b1, "R7 still high", 32'(dout), 1);
        wait_n(16);
        chk(dout == 1'b0, "R7 ready", 32'(dout), 0);
        chk(cal_pending == 1'b0, "R9 no cal", 32'(cal_pending), 0);
        acc = '0;
        read_bits(W, acc);
        chk(acc == 24'h123456, "R9 new word", 32'(acc), 32'h123456);

        // R3: extra pulse arms calibration
        pulse(b);
        chk(b == 1'b1, "R3 dout high", 32'(b), 1);
        chk(cal_pending == 1'b1, "R3 cal armed", 32'(cal_pending), 1);

        // R8: calibration wake
        @(negedge clk);
        sclk = 1'b1;
        wait_n(TACT + 10);
        chk(asleep == 1'b1, "R4 asleep after cal arm", 32'(asleep), 1);
        res_data = 24'h9E3779;
        sclk = 1'b0;
        wait_n(40);
        chk(dout == 1'b1, "R8 still high", 32'(dout), 1);
        chk(cal_pending == 1'b1, "R8 cal held", 32'(cal_pending), 1);
        wait_n(60);
        chk(dout == 1'b0, "R8 ready", 32'(dout), 0);
        chk(cal_pending == 1'b0, "R8 cal cleared", 32'(cal_pending), 0);
        acc = '0;
        read_bits(W, acc);
        chk(acc == 24'h9E3779, "R8 word", 32'(acc), 32'h9E3779);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule